// File: doc/BRIEF.md
# Ring descriptor address stepper

This block walks a ring of DMA descriptors held in memory and keeps a pointer to the current one. The engine restarts it with a ring base address, a descriptor size and a skip length. These values are stored and held until the next restart. Each advance strobe then moves the pointer forward by one stride. The stride is the descriptor size plus an empty gap of a whole number of bus words. When the descriptor just processed carries the ring-end flag, the pointer goes back to the stored base instead.

Alongside the address, the block reports how many bytes the fetch logic must read for the current descriptor: 16 or 32. The bus width is a build parameter of 32, 64 or 128 bits, and it sets the size of one skip word. The block does not read descriptor contents and does not access memory. Its outputs are registered, so a restart or an advance shows at the outputs one clock after the edge that samples it.

Top module: `rds_ring_stepper`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `desc_addr_o` is 0 and `fetch_bytes_o` is 16. The stored base and skip are 0 and the stored size is 16 bytes.
- R2: A clock edge with `restart_i` high loads `ring_base_i`, `skip_len_i` and `desc_wide_i` into the block. From the next cycle, `desc_addr_o` equals the loaded base.
- R3: A clock edge with `advance_i` high, `ring_end_i` low and `restart_i` low adds the stride to `desc_addr_o`. The stride is descriptor bytes plus skip × word bytes.
- R4: One skip word is BUS_W/8 bytes: 4, 8 or 16 for a 32-, 64- or 128-bit bus.
- R5: A stored skip of 0 makes the stride equal the descriptor size, so descriptors sit back to back.
- R6: `desc_wide_i` = 0 selects 16-byte descriptors and 1 selects 32-byte descriptors. `fetch_bytes_o` shows the stored size as 16 or 32.
- R7: A clock edge with `advance_i` and `ring_end_i` both high and `restart_i` low sets `desc_addr_o` to the base stored at the last restart.
- R8: When `restart_i` and `advance_i` are high at the same edge, the restart wins. The result is the new base, with no stride added.
- R9: Changes on `ring_base_i`, `skip_len_i` or `desc_wide_i` without `restart_i` have no effect on later strides, on `fetch_bytes_o`, or on the address a ring-end wrap returns to.
- R10: With neither `restart_i` nor `advance_i` high, `desc_addr_o` holds its value.
- R11: Address arithmetic is modulo 2^ADDR_W, so a step past the top of the address space wraps to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| restart_i | input | 1 | Reload the pointer and the stored configuration |
| ring_base_i | input | ADDR_W | Start address of the ring |
| skip_len_i | input | 5 | Empty bus words between descriptors |
| desc_wide_i | input | 1 | Descriptor size select: 0 = 16 bytes, 1 = 32 bytes |
| advance_i | input | 1 | Step to the next descriptor |
| ring_end_i | input | 1 | The current descriptor is the last in the ring |
| desc_addr_o | output | ADDR_W | Address of the current descriptor |
| fetch_bytes_o | output | 6 | Bytes to fetch for the current descriptor |

## Verification
The bench builds the block with a 128-bit bus and 32-bit addresses. This gives the widest skip word and the largest stride: 32 + 31 × 16 = 528 bytes. A restart near the top of the address space reaches the modulo wrap. The vector table mixes both descriptor sizes with skip lengths of 0, 2 and 31. It also covers a restart coinciding with an advance, and reprogramming of the inputs without a restart, which must have no effect. Reset is checked at power-up and again in the middle of a run.

// File: rtl/rds_pkg.sv
package rds_pkg;

  // Width of the skip-length field, in bits.
  localparam int SKIP_W = 5;

  // Descriptor size selector.
  typedef enum logic {
    DSZ_16 = 1'b0,
    DSZ_32 = 1'b1
  } desc_size_e;

  // Configuration latched when the engine restarts.
  typedef struct packed {
    desc_size_e              size;
    logic [SKIP_W-1:0]       skip;
  } ring_cfg_t;

  // Bytes held by one bus word.
  function automatic int unsigned word_bytes(input int unsigned bus_w);
    return bus_w / 8;
  endfunction

  // Bytes occupied by one descriptor.
  function automatic logic [5:0] desc_bytes(input desc_size_e sz);
    return (sz == DSZ_32) ? 6'd32 : 6'd16;
  endfunction

  // Distance from one descriptor start to the next.
  function automatic int unsigned stride_bytes(input desc_size_e sz,
                                               input logic [SKIP_W-1:0] skip,
                                               input int unsigned wbytes);
    return int'(desc_bytes(sz)) + int'(skip) * wbytes;
  endfunction

endpackage

// File: rtl/rds_cfg_reg.sv
module rds_cfg_reg
  import rds_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [SKIP_W-1:0]    skip_i,
  input  logic                 wide_i,
  output logic [ADDR_W-1:0]    base_q,
  output ring_cfg_t            cfg_q
);

  // Configuration captured on restart.
  ring_cfg_t cfg_d;

  always_comb begin
    cfg_d.size = wide_i ? DSZ_32 : DSZ_16;
    cfg_d.skip = skip_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      cfg_q.size <= DSZ_16;
      cfg_q.skip <= '0;
    end else if (restart_i) begin
      base_q <= base_i;
      cfg_q  <= cfg_d;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> ($stable(cfg_q) && $stable(base_q))); // R9
  AST_CFG_SKIP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cfg_q.skip == $past(skip_i))); // R2
  AST_CFG_SIZE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> ((cfg_q.size == DSZ_32) == $past(wide_i))); // R6

endmodule

// File: rtl/rds_stride_calc.sv
module rds_stride_calc
  import rds_pkg::*;
#(
  parameter int BUS_W    = 64,
  parameter int STRIDE_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ring_cfg_t            cfg_i,
  output logic [STRIDE_W-1:0]  stride_o,
  output logic [5:0]           desc_bytes_o
);

  localparam int unsigned WORD_BYTES = word_bytes(BUS_W);
  localparam int          WORD_SHIFT = $clog2(WORD_BYTES);
  localparam int          SKIPB_W    = SKIP_W + WORD_SHIFT;

  // Gap in bytes, formed by shifting the skip count by the word size.
  logic [SKIPB_W-1:0] skip_bytes;

  generate
    if (WORD_SHIFT == 0) begin : g_byte_word
      assign skip_bytes = cfg_i.skip;
    end else begin : g_wide_word
      assign skip_bytes = {cfg_i.skip, {WORD_SHIFT{1'b0}}};
    end
  endgenerate

  assign desc_bytes_o = desc_bytes(cfg_i.size);
  assign stride_o     = STRIDE_W'(desc_bytes_o) + STRIDE_W'(skip_bytes);

  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.skip == '0) |-> (stride_o == STRIDE_W'(desc_bytes_o))); // R5
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_bytes_o == 6'd16) || (desc_bytes_o == 6'd32)); // R6
  AST_STRIDE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (STRIDE_W'(stride_o - STRIDE_W'(desc_bytes_o)) % STRIDE_W'(WORD_BYTES)) == '0); // R4

endmodule

// File: rtl/rds_ptr.sv
module rds_ptr #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart_i,
  input  logic                 advance_i,
  input  logic                 ring_end_i,
  input  logic [ADDR_W-1:0]    load_base_i,
  input  logic [ADDR_W-1:0]    wrap_base_i,
  input  logic [STRIDE_W-1:0]  stride_i,
  output logic [ADDR_W-1:0]    addr_q
);

  // Named events for the checks below.
  logic ev_load;
  logic ev_wrap;
  logic ev_step;
  logic [ADDR_W-1:0] addr_d;

  assign ev_load = restart_i;
  assign ev_wrap = advance_i && ring_end_i && !restart_i;
  assign ev_step = advance_i && !ring_end_i && !restart_i;

  always_comb begin
    addr_d = addr_q;
    if (ev_load)      addr_d = load_base_i;
    else if (ev_wrap) addr_d = wrap_base_i;
    else if (ev_step) addr_d = addr_q + ADDR_W'(stride_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (addr_q == $past(load_base_i))); // R2
  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> (addr_q == $past(wrap_base_i))); // R7
  AST_STEP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (addr_q == $past(addr_q) + ADDR_W'($past(stride_i)))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !advance_i) |=> $stable(addr_q)); // R10

endmodule

// File: rtl/rds_ring_stepper.sv
module rds_ring_stepper
  import rds_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart_i,
  input  logic [ADDR_W-1:0]    ring_base_i,
  input  logic [SKIP_W-1:0]    skip_len_i,
  input  logic                 desc_wide_i,
  input  logic                 advance_i,
  input  logic                 ring_end_i,
  output logic [ADDR_W-1:0]    desc_addr_o,
  output logic [5:0]           fetch_bytes_o
);

  localparam int WORD_SHIFT = $clog2(BUS_W / 8);
  localparam int STRIDE_W   = SKIP_W + WORD_SHIFT + 2;

  logic [ADDR_W-1:0]   base_q;
  ring_cfg_t           cfg_q;
  logic [STRIDE_W-1:0] stride;
  logic [5:0]          dbytes;

  rds_cfg_reg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_i),
    .base_i    (ring_base_i),
    .skip_i    (skip_len_i),
    .wide_i    (desc_wide_i),
    .base_q    (base_q),
    .cfg_q     (cfg_q)
  );

  rds_stride_calc #(.BUS_W(BUS_W), .STRIDE_W(STRIDE_W)) u_stride (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg_q),
    .stride_o     (stride),
    .desc_bytes_o (dbytes)
  );

  rds_ptr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (restart_i),
    .advance_i   (advance_i),
    .ring_end_i  (ring_end_i),
    .load_base_i (ring_base_i),
    .wrap_base_i (base_q),
    .stride_i    (stride),
    .addr_q      (desc_addr_o)
  );

  assign fetch_bytes_o = dbytes;

  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && advance_i) |=> (desc_addr_o == $past(ring_base_i))); // R8
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> $stable(fetch_bytes_o)); // R9

endmodule

// File: tb/rds_ring_stepper_tb.sv
module rds_ring_stepper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int BUS_W      = 128;
  localparam int NVEC       = 13;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              restart_i;
  logic [ADDR_W-1:0] ring_base_i;
  logic [4:0]        skip_len_i;
  logic              desc_wide_i;
  logic              advance_i;
  logic              ring_end_i;
  logic [ADDR_W-1:0] desc_addr_o;
  logic [5:0]        fetch_bytes_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rds_ring_stepper #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart_i     (restart_i),
    .ring_base_i   (ring_base_i),
    .skip_len_i    (skip_len_i),
    .desc_wide_i   (desc_wide_i),
    .advance_i     (advance_i),
    .ring_end_i    (ring_end_i),
    .desc_addr_o   (desc_addr_o),
    .fetch_bytes_o (fetch_bytes_o)
  );

  typedef struct packed {
    logic        rs;
    logic        adv;
    logic        rend;
    logic [31:0] base;
    logic [4:0]  skip;
    logic        wide;
    logic [31:0] exp_addr;
    logic [5:0]  exp_bytes;
    logic [7:0]  req;
  } vec_t;

  // Word is 16 bytes on a 128-bit bus.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 32'h0000_1000, 5'd0,  1'b0, 32'h0000_1000, 6'd16, 8'd2},  // R2
    '{1'b0, 1'b1, 1'b0, 32'h0000_1000, 5'd0,  1'b0, 32'h0000_1010, 6'd16, 8'd5},  // R5
    '{1'b0, 1'b1, 1'b0, 32'h0000_1000, 5'd0,  1'b0, 32'h0000_1020, 6'd16, 8'd5},  // R5
    '{1'b0, 1'b1, 1'b1, 32'h0000_1000, 5'd0,  1'b0, 32'h0000_1000, 6'd16, 8'd7},  // R7
    '{1'b1, 1'b0, 1'b0, 32'h0000_2000, 5'd2,  1'b1, 32'h0000_2000, 6'd32, 8'd6},  // R6
    '{1'b0, 1'b1, 1'b0, 32'h0000_2000, 5'd2,  1'b1, 32'h0000_2040, 6'd32, 8'd4},  // R4 R3
    '{1'b0, 1'b1, 1'b0, 32'h0000_9000, 5'd31, 1'b0, 32'h0000_2080, 6'd32, 8'd9},  // R9
    '{1'b0, 1'b0, 1'b0, 32'h0000_9000, 5'd31, 1'b0, 32'h0000_2080, 6'd32, 8'd10}, // R10
    '{1'b0, 1'b1, 1'b1, 32'h0000_9000, 5'd31, 1'b0, 32'h0000_2000, 6'd32, 8'd9},  // R9 wrap base
    '{1'b1, 1'b1, 1'b0, 32'h0000_3000, 5'd31, 1'b0, 32'h0000_3000, 6'd16, 8'd8},  // R8
    '{1'b0, 1'b1, 1'b0, 32'h0000_3000, 5'd31, 1'b0, 32'h0000_3200, 6'd16, 8'd3},  // R3
    '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFF0, 5'd0,  1'b1, 32'hFFFF_FFF0, 6'd32, 8'd2},  // R2
    '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFF0, 5'd0,  1'b1, 32'h0000_0010, 6'd32, 8'd11}  // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    restart_i   = 1'b0;
    advance_i   = 1'b0;
    ring_end_i  = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired (all requirements)");
    report();
  end

  initial begin
    rst_n       = 1'b0;
    ring_base_i = 32'h0000_5550;
    skip_len_i  = 5'd7;
    desc_wide_i = 1'b1;
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr in reset", desc_addr_o, 32'h0);
    check("R1 bytes in reset", 32'(fetch_bytes_o), 32'd16);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr after release", desc_addr_o, 32'h0);
    check("R1 bytes after release", 32'(fetch_bytes_o), 32'd16);

    for (int i = 0; i < NVEC; i++) begin
      restart_i   = VECS[i].rs;
      advance_i   = VECS[i].adv;
      ring_end_i  = VECS[i].rend;
      ring_base_i = VECS[i].base;
      skip_len_i  = VECS[i].skip;
      desc_wide_i = VECS[i].wide;
      @(posedge clk);
      @(negedge clk);
      drive_idle();
      check($sformatf("R%0d vec %0d addr", VECS[i].req, i), desc_addr_o, VECS[i].exp_addr);
      check($sformatf("R%0d vec %0d bytes", VECS[i].req, i), 32'(fetch_bytes_o), 32'(VECS[i].exp_bytes));
    end

    // Mid-run reset returns to the reset state: R1
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 mid-run reset addr", desc_addr_o, 32'h0);
    check("R1 mid-run reset bytes", 32'(fetch_bytes_o), 32'd16);

    // After reset the stored skip is 0 and size 16: advance gives 16 (R1, R5)
    ring_base_i = 32'h0000_7000;
    skip_len_i  = 5'd9;
    desc_wide_i = 1'b1;
    advance_i   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive_idle();
    check("R1 reset cfg stride", desc_addr_o, 32'h0000_0010);
    report();
  end

endmodule